// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block sits on the host side of an asynchronous byte-wide flash bus. The bus has active-low chip-select, read-strobe and write-strobe lines, a byte-wide address-plus-data path, and a split data bus made of an output value, an output enable and an input value. A client hands it one request at a time on a valid/ready handshake. The request asks for one of three jobs: write a byte, clear the whole array, or fetch an identification byte.

For each request the controller builds the whole bus command stream itself. It drives the unlock writes to the two fixed command addresses, then the command byte, then any payload. Every strobe lasts for a number of clock cycles set by a parameter. A byte write or array clear then ends by polling the flash. A write polls bit 7 of the target byte. A clear polls the toggling bit 6. Nothing waits a fixed delay. If the poll limit runs out, the request ends with an error flag.

For an identification fetch the controller enters identification mode, reads one byte at the requested address, and sends the single-write exit command. It then returns that byte. Completion is reported by a one-cycle `done` pulse together with `err`.

Top module: `pflash_prog_ctrl`

## Requirements
- R1: While reset is held, and right after it, `req_ready` is 1, `done` is 0, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1 and `flash_dq_oe` is 0.
- R2: A byte-write request (`req_op`=0) produces exactly four bus writes, each captured at the rising write strobe:
  - 0xAA to 0x5555
  - 0x55 to 0x2AAA
  - 0xA0 to 0x5555
  - `req_data` to `req_addr`
- R3: An array-clear request (`req_op`=1) produces exactly six bus writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555.
- R4: An identification request (`req_op`=2) performs these bus cycles, and `rd_data` then holds the byte that was read:
  - writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555
  - one read at `req_addr`
  - the exit write 0xF0@0x5555
- R5: Each low write-strobe pulse lasts at least WE_LOW_CYC cycles. The write strobe stays high for at least WE_HIGH_CYC cycles between pulses.
- R6: `flash_addr` is stable whenever chip-select stays low. `flash_dq_out` is stable while the write strobe is low. The read strobe is high whenever the write strobe is low.
- R7: `flash_dq_oe` is 1 at every rising write strobe. It is 0 whenever the read strobe is low. It is 0 in the cycle before the read strobe falls.
- R8: A byte write finishes after the first poll read whose bit 7 equals bit 7 of the written data, with `err`=0.
- R9: An array clear finishes after the first poll read whose bit 6 equals bit 6 of the previous poll read, with `err`=0. All poll reads use `req_addr`. The read strobe stays high for at least OE_HIGH_CYC cycles between reads.
- R10: If POLL_LIMIT poll reads pass without completion, `done` pulses with `err`=1 and the controller returns to idle, ready for a new request.
- R11: `req_ready` is 1 only when the controller is idle. After a valid request is accepted it drops in the next cycle. `done` is a one-cycle pulse, and `req_ready` is 1 during it.
- R12: A request with `req_op`=3 causes no bus cycle. It gives `done`=1 with `err`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | 0 byte write, 1 array clear, 2 identification read, 3 illegal |
| req_addr | input | ADDR_W | Target byte address (write, poll and identification address) |
| req_data | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with done: timeout or illegal request |
| rd_data | output | 8 | Byte returned by the last identification read |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_oe_n | output | 1 | Flash read strobe, active low |
| flash_we_n | output | 1 | Flash write strobe, active low |
| flash_dq_out | output | 8 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_out |
| flash_dq_in | input | 8 | Data returned by the flash |

## Verification
A wrong step counter or command pointer shows up at the first rising write strobe of a request: the captured address/data pair differs from the expected unlock stream. A wrong poll state shows up within one read period as a wrong poll-read count or a wrong `err`, because the bench flash model sets exactly how many reads report busy. A timing-counter fault shows up within one strobe. A write strobe that is too short, a read strobe that is too close to the last one, or a data driver still on when the read strobe falls is flagged by the per-clock monitor on the very edge where it happens.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_ID    = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_WRITE = 8'hA0;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CLEAR = 8'h10;
  localparam logic [7:0] CMD_IDIN  = 8'h90;
  localparam logic [7:0] CMD_IDOUT = 8'hF0;

endpackage

// File: rtl/pflash_cmd_rom.sv
module pflash_cmd_rom
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  op_e               op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic              step_wr,
  output logic [ADDR_W-1:0] step_addr,
  output logic [7:0]        step_data,
  output logic              step_last
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_B);

  always_comb begin
    step_wr   = 1'b1;
    step_addr = ADR_A;
    step_data = CMD_KEY1;
    step_last = 1'b0;
    case (op)
      OP_PROG: begin
        case (idx)
          3'd0: ;
          3'd1: begin step_addr = ADR_B; step_data = CMD_KEY2; end
          3'd2: step_data = CMD_WRITE;
          default: begin
            step_addr = tgt_addr;
            step_data = tgt_data;
            step_last = 1'b1;
          end
        endcase
      end
      OP_ERASE: begin
        case (idx)
          3'd0, 3'd3: ;
          3'd1, 3'd4: begin step_addr = ADR_B; step_data = CMD_KEY2; end
          3'd2: step_data = CMD_SETUP;
          default: begin step_data = CMD_CLEAR; step_last = 1'b1; end
        endcase
      end
      OP_ID: begin
        case (idx)
          3'd0: ;
          3'd1: begin step_addr = ADR_B; step_data = CMD_KEY2; end
          3'd2: step_data = CMD_IDIN;
          3'd3: begin step_wr = 1'b0; step_addr = tgt_addr; step_data = 8'h00; end
          default: begin step_data = CMD_IDOUT; step_last = 1'b1; end
        endcase
      end
      default: step_last = 1'b1;
    endcase
  end

endmodule

// File: rtl/pflash_bus_cycle.sv
module pflash_bus_cycle #(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 10,
  parameter int RD_CYC      = 6,
  parameter int OE_HIGH_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        wdata,
  output logic              cyc_done,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic [7:0]        dq_in
);

  localparam int MAX_A = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAX_B = (RD_CYC > OE_HIGH_CYC) ? RD_CYC : OE_HIGH_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bst_e;

  bst_e             st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic [CNT_W-1:0] strobe_end;
  logic [CNT_W-1:0] recov_end;

  assign strobe_end = wr_q ? CNT_W'(WE_LOW_CYC - 1) : CNT_W'(RD_CYC - 1);
  assign recov_end  = wr_q ? CNT_W'(WE_HIGH_CYC - 1) : CNT_W'(OE_HIGH_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      bus_addr <= '0;
      rdata    <= '0;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          bus_addr <= addr_in;
          dq_out   <= wdata;
          dq_oe    <= wr;
          wr_q     <= wr;
          ce_n     <= 1'b0;
          st       <= B_SETUP;
        end
        B_SETUP: begin
          cnt <= '0;
          if (wr_q) we_n <= 1'b0;
          else      oe_n <= 1'b0;
          st <= B_STROBE;
        end
        B_STROBE: begin
          if (cnt == strobe_end) begin
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            ce_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (!wr_q) rdata <= dq_in;
            cnt <= '0;
            st  <= B_RECOV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == recov_end) begin
            cyc_done <= 1'b1;
            st       <= B_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pflash_prog_ctrl.sv
module pflash_prog_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 10,
  parameter int RD_CYC      = 6,
  parameter int OE_HIGH_CYC = 8,
  parameter int POLL_LIMIT  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              done,
  output logic              err,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  output logic [7:0]        flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [7:0]        flash_dq_in
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} tst_e;

  tst_e              st;
  op_e               op_q;
  logic [ADDR_W-1:0] tgt_a;
  logic [7:0]        tgt_d;
  logic [2:0]        idx;
  logic              polling;
  logic [PC_W-1:0]   npoll;
  logic              prev6;
  logic              have_prev;
  logic              start_q;
  logic              cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic              done_q;
  logic              err_q;
  logic [7:0]        rd_q;

  logic              step_wr;
  logic [ADDR_W-1:0] step_addr;
  logic [7:0]        step_data;
  logic              step_last;
  logic              cyc_done;
  logic [7:0]        rdata;
  logic              poll_ok;

  pflash_cmd_rom #(.ADDR_W(ADDR_W)) u_rom (
    .op(op_q), .idx(idx), .tgt_addr(tgt_a), .tgt_data(tgt_d),
    .step_wr(step_wr), .step_addr(step_addr), .step_data(step_data),
    .step_last(step_last)
  );

  pflash_bus_cycle #(
    .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .RD_CYC(RD_CYC), .OE_HIGH_CYC(OE_HIGH_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .start(start_q), .wr(cmd_wr), .addr_in(cmd_addr),
    .wdata(cmd_data), .cyc_done(cyc_done), .rdata(rdata),
    .bus_addr(flash_addr), .ce_n(flash_ce_n), .oe_n(flash_oe_n),
    .we_n(flash_we_n), .dq_out(flash_dq_out), .dq_oe(flash_dq_oe),
    .dq_in(flash_dq_in)
  );

  always_comb begin
    if (op_q == OP_PROG) poll_ok = (rdata[7] == tgt_d[7]);
    else                 poll_ok = have_prev && (rdata[6] == prev6);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      op_q      <= OP_PROG;
      tgt_a     <= '0;
      tgt_d     <= '0;
      idx       <= '0;
      polling   <= 1'b0;
      npoll     <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      start_q   <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      case (st)
        T_IDLE: if (req_valid) begin
          if (op_e'(req_op) == OP_BAD) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            op_q      <= op_e'(req_op);
            tgt_a     <= req_addr;
            tgt_d     <= req_data;
            idx       <= '0;
            polling   <= 1'b0;
            npoll     <= '0;
            have_prev <= 1'b0;
            err_q     <= 1'b0;
            st        <= T_ISSUE;
          end
        end
        T_ISSUE: begin
          start_q <= 1'b1;
          if (polling) begin
            cmd_wr   <= 1'b0;
            cmd_addr <= tgt_a;
            cmd_data <= '0;
          end else begin
            cmd_wr   <= step_wr;
            cmd_addr <= step_addr;
            cmd_data <= step_data;
          end
          st <= T_WAIT;
        end
        T_WAIT: if (cyc_done) begin
          if (!polling) begin
            if (!cmd_wr) rd_q <= rdata;
            if (step_last) begin
              if (op_q == OP_ID) begin
                done_q <= 1'b1;
                st     <= T_IDLE;
              end else begin
                polling <= 1'b1;
                st      <= T_ISSUE;
              end
            end else begin
              idx <= idx + 1'b1;
              st  <= T_ISSUE;
            end
          end else begin
            npoll     <= npoll + 1'b1;
            prev6     <= rdata[6];
            have_prev <= 1'b1;
            if (poll_ok) begin
              done_q <= 1'b1;
              st     <= T_IDLE;
            end else if (npoll == PC_W'(POLL_LIMIT - 1)) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              st     <= T_IDLE;
            end else begin
              st <= T_ISSUE;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (st == T_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_data   = rd_q;

endmodule

// File: rtl/pflash_prog_ctrl_chk.sv
module pflash_prog_ctrl_chk #(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 10,
  parameter int OE_HIGH_CYC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              flash_we_n,
  input logic [7:0]        flash_dq_out,
  input logic              flash_dq_oe
);

  logic [15:0] we_lo_run, we_hi_run, oe_hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_run <= '0;
      we_hi_run <= '1;
      oe_hi_run <= '1;
    end else begin
      we_lo_run <= flash_we_n ? 16'd0 : we_lo_run + 16'd1;
      if (!flash_we_n)         we_hi_run <= '0;
      else if (we_hi_run != '1) we_hi_run <= we_hi_run + 16'd1;
      if (!flash_oe_n)         oe_hi_run <= '0;
      else if (oe_hi_run != '1) oe_hi_run <= oe_hi_run + 16'd1;
    end
  end

  p_we_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we_n) |-> we_lo_run >= 16'(WE_LOW_CYC));
  p_we_high_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_we_n) |-> we_hi_run >= 16'(WE_HIGH_CYC));
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!flash_we_n && $past(!flash_we_n)) |-> $stable(flash_dq_out));
  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> flash_oe_n);
  p_dq_off_read_r7: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> !flash_dq_oe);
  p_dq_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_oe_n) |-> $past(!flash_dq_oe));
  p_oe_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_oe_n) |-> oe_hi_run >= 16'(OE_HIGH_CYC));
  p_ready_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op != 2'd3) |=> !req_ready);
  p_done_ready_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);
  p_bad_op_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd3) |=> (done && err));

endmodule

bind pflash_prog_ctrl pflash_prog_ctrl_chk #(
  .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
  .OE_HIGH_CYC(OE_HIGH_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .done(done), .err(err), .flash_addr(flash_addr),
  .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
  .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe)
);

// File: tb/pflash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module pflash_prog_ctrl_tb;

  localparam int AW = 19;
  localparam int WL = 10;
  localparam int WH = 10;
  localparam int RC = 6;
  localparam int OH = 8;
  localparam int PL = 12;
  localparam logic [7:0] ID0 = 8'h5A;
  localparam logic [7:0] ID1 = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, err;
  logic [7:0]    rd_data;
  logic [AW-1:0] flash_addr;
  logic          flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe;
  logic [7:0]    flash_dq_out, flash_dq_in;

  pflash_prog_ctrl #(
    .ADDR_W(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .RD_CYC(RC),
    .OE_HIGH_CYC(OH), .POLL_LIMIT(PL)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
    .err(err), .rd_data(rd_data), .flash_addr(flash_addr),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural flash model
  int         m_kind = 0;
  logic [7:0] m_data = 8'h00;
  int         m_busy = 0;
  int         rise_base = 0;
  int         n_rises = 0;
  int         n_falls = 0;
  int         n_cap = 0;
  logic [AW-1:0] cap_a [256];
  logic [7:0]    cap_d [256];
  logic [AW-1:0] rd_a  [256];

  always_comb begin
    if (flash_oe_n) flash_dq_in = 8'h00;
    else if (m_kind == 0)
      flash_dq_in = ((n_rises - rise_base) < m_busy) ?
                    {~m_data[7], 1'((n_rises - rise_base) & 1), m_data[5:0]} : m_data;
    else if (m_kind == 1)
      flash_dq_in = ((n_rises - rise_base) < m_busy) ?
                    {1'b0, 1'((n_rises - rise_base) & 1), 6'h00} : 8'hFF;
    else
      flash_dq_in = flash_addr[0] ? ID1 : ID0;
  end

  // per-clock bus monitor
  logic          p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1, p_dqoe = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0]    p_dq = '0;
  int we_lo_run = 0, we_hi_run = 1000, oe_hi_run = 1000;

  always @(negedge clk) begin
    if (!rst) begin
      if (!flash_we_n) chk(flash_oe_n, "R6", "read strobe low during write", flash_oe_n, 1);
      if (!flash_oe_n) chk(!flash_dq_oe, "R7", "driver on during read", flash_dq_oe, 0);
      if (!flash_ce_n && !p_ce) chk(flash_addr == p_addr, "R6", "addr moved", flash_addr, p_addr);
      if (!flash_we_n && !p_we) chk(flash_dq_out == p_dq, "R6", "data moved", flash_dq_out, p_dq);
      if (!p_we && flash_we_n) begin
        chk(we_lo_run >= WL, "R5", "write low width", we_lo_run, WL);
        chk(p_dqoe, "R7", "driver off at write latch", p_dqoe, 1);
        if (n_cap < 256) begin
          cap_a[n_cap] = p_addr;
          cap_d[n_cap] = p_dq;
        end
        n_cap++;
      end
      if (p_we && !flash_we_n) chk(we_hi_run >= WH, "R5", "write high gap", we_hi_run, WH);
      if (p_oe && !flash_oe_n) begin
        chk(!p_dqoe, "R7", "driver on before read", p_dqoe, 0);
        chk(oe_hi_run >= OH, "R9", "read high gap", oe_hi_run, OH);
        if (n_falls < 256) rd_a[n_falls] = flash_addr;
        n_falls++;
      end
      if (!p_oe && flash_oe_n) n_rises++;
      we_lo_run = flash_we_n ? 0 : we_lo_run + 1;
      we_hi_run = flash_we_n ? we_hi_run + 1 : 0;
      oe_hi_run = flash_oe_n ? oe_hi_run + 1 : 0;
    end
    p_we = flash_we_n; p_oe = flash_oe_n; p_ce = flash_ce_n;
    p_dqoe = flash_dq_oe; p_addr = flash_addr; p_dq = flash_dq_out;
  end

  function automatic int erase_reads(input int b);
    int prev = -1;
    for (int k = 1; k <= PL; k++) begin
      int v = (k <= b) ? ((k - 1) % 2) : 1;
      if (k >= 2 && v == prev) return k;
      prev = v;
    end
    return PL;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input int busy, input string tag);
    logic [AW-1:0] ea[$];
    logic [7:0]    ed[$];
    int exp_reads, cap_base, fall_base, cyc;
    bit exp_err;
    case (op)
      2'd0: begin
        ea = '{AW'(19'h5555), AW'(19'h2AAA), AW'(19'h5555), a};
        ed = '{8'hAA, 8'h55, 8'hA0, d};
        exp_reads = (busy + 1 <= PL) ? busy + 1 : PL;
        exp_err = (busy + 1 > PL);
      end
      2'd1: begin
        ea = '{AW'(19'h5555), AW'(19'h2AAA), AW'(19'h5555),
               AW'(19'h5555), AW'(19'h2AAA), AW'(19'h5555)};
        ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        exp_reads = erase_reads(busy);
        exp_err = 1'b1;
        for (int k = 2; k <= PL; k++)
          if (((k <= busy) ? ((k - 1) % 2) : 1) == ((k - 1 <= busy) ? ((k - 2) % 2) : 1))
            exp_err = 1'b0;
      end
      2'd2: begin
        ea = '{AW'(19'h5555), AW'(19'h2AAA), AW'(19'h5555), AW'(19'h5555)};
        ed = '{8'hAA, 8'h55, 8'h90, 8'hF0};
        exp_reads = 1;
        exp_err = 1'b0;
      end
      default: begin
        exp_reads = 0;
        exp_err = 1'b1;
      end
    endcase
    m_kind = int'(op); m_data = d; m_busy = busy; rise_base = n_rises;
    cap_base = n_cap; fall_base = n_falls;
    @(negedge clk);
    chk(req_ready, "R11", {tag, " ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (op != 2'd3) chk(!req_ready, "R11", {tag, " ready after accept"}, req_ready, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R11", {tag, " done seen"}, done, 1);
    chk(req_ready, "R11", {tag, " ready with done"}, req_ready, 1);
    chk(err == exp_err, exp_err ? "R10" : "R8", {tag, " err"}, err, exp_err);
    chk(n_cap - cap_base == ea.size(), (op == 2'd1) ? "R3" : "R2",
        {tag, " write count"}, n_cap - cap_base, ea.size());
    for (int i = 0; i < ea.size() && cap_base + i < n_cap; i++) begin
      chk(cap_a[cap_base + i] == ea[i], (op == 2'd1) ? "R3" : (op == 2'd2) ? "R4" : "R2",
          {tag, " write addr"}, cap_a[cap_base + i], ea[i]);
      chk(cap_d[cap_base + i] == ed[i], (op == 2'd1) ? "R3" : (op == 2'd2) ? "R4" : "R2",
          {tag, " write data"}, cap_d[cap_base + i], ed[i]);
    end
    chk(n_falls - fall_base == exp_reads, (op == 2'd1) ? "R9" : "R8",
        {tag, " read count"}, n_falls - fall_base, exp_reads);
    for (int i = fall_base; i < n_falls; i++)
      chk(rd_a[i] == a, "R9", {tag, " poll address"}, rd_a[i], a);
    if (op == 2'd2)
      chk(rd_data == (a[0] ? ID1 : ID0), "R4", {tag, " id byte"}, rd_data, a[0] ? ID1 : ID0);
    @(negedge clk);
    chk(!done, "R11", {tag, " done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(req_ready && !done && flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe,
        "R1", "outputs in reset", {req_ready, done, flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe},
        6'b101110);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && flash_we_n && !flash_dq_oe, "R1", "idle after reset",
        {req_ready, done, flash_we_n, flash_dq_oe}, 4'b1010);
    run_op(2'd0, 19'h12345, 8'h3C, 3, "R2 R8 prog busy3");
    run_op(2'd0, 19'h7FFFF, 8'h80, 0, "R2 R8 prog bit7 one");
    run_op(2'd1, 19'h00400, 8'h00, 4, "R3 R9 erase busy4");
    run_op(2'd1, 19'h00401, 8'h00, 3, "R3 R9 erase busy3");
    run_op(2'd1, 19'h00000, 8'h00, 0, "R3 R9 erase busy0");
    run_op(2'd2, 19'h00000, 8'h00, 0, "R4 id low");
    run_op(2'd2, 19'h00001, 8'h00, 0, "R4 id high");
    run_op(2'd0, 19'h01010, 8'h55, 100, "R10 prog timeout");
    run_op(2'd1, 19'h02020, 8'h00, 100, "R10 erase timeout");
    run_op(2'd0, 19'h03030, 8'hA5, 2, "R10 recovery prog");
    run_op(2'd3, 19'h00010, 8'h00, 0, "R12 bad op");
    run_op(2'd0, 19'h00011, 8'h01, 1, "R12 after bad op");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule